// File: doc/BRIEF.md
# Load-Use Hazard Stall Controller

This block sits in the decode stage of a five-stage in-order pipeline. It finds the one dependence that forwarding cannot cover: the instruction in decode needs a register that a load, now in execute, has not yet returned from memory. When that happens it stalls the front of the pipeline for a single cycle. It freezes the program counter and the fetch/decode register, and it sends an all-zero control word into the decode/execute register. That bubble carries no register write and no memory write, so it changes nothing as it moves down the pipeline. On the following cycle the dependent instruction enters execute, where forwarding supplies the loaded value.

To make the stall visible, the module holds small working models of three registers: the program counter, the fetch/decode register (source fields and control word) and the control part of the decode/execute register (control word and destination field). The surrounding bench acts as the instruction memory. It reads `pc` and presents the source fields and the predecoded control word of the instruction at that address on the fetch inputs.

Top module: `load_use_stall`

## Requirements
- R1: `stall` is high in the same cycle when bit MEMRD_BIT (bit 2) of `ex_ctrl` is set, `ex_rt` is nonzero, and `ex_rt` equals `id_rs` or `id_rt`.
- R2: A load whose destination is register 0 never raises `stall`.
- R3: `pc_we` and `ifid_we` are both low in every cycle where `stall` is high, and both high in every other cycle.
- R4: On a clock edge where `stall` is high, `pc`, `id_rs`, `id_rt` and `id_ctrl` keep their values.
- R5: On a clock edge where `stall` is high, `ex_ctrl` is loaded with all zeros, so the register-write bit (bit 0) and the memory-write bit (bit 1) are clear.
- R6: A stall lasts exactly one cycle. On the next edge the held instruction enters execute with its control word unchanged.
- R7: On an edge without a stall, `ex_ctrl` takes `id_ctrl` unchanged and `pc` advances by PC_STEP.
- R8: While `rst_n` is low, `pc`, `id_rs`, `id_rt`, `id_ctrl`, `ex_ctrl` and `ex_rt` are zero.
- R9: A load followed by an unrelated instruction, or followed by a dependent instruction two or more slots later, causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| f_rs | input | REG_BITS | First source register of the fetched instruction |
| f_rt | input | REG_BITS | Second source / load destination of the fetched instruction |
| f_ctrl | input | CTRL_BITS | Predecoded control word of the fetched instruction |
| pc | output | PC_BITS | Program counter model |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| stall | output | 1 | Hazard flag; selects the zero control word into execute |
| id_rs | output | REG_BITS | Decode-stage first source register |
| id_rt | output | REG_BITS | Decode-stage second source register |
| id_ctrl | output | CTRL_BITS | Decode-stage control word |
| ex_ctrl | output | CTRL_BITS | Execute-stage control word |
| ex_rt | output | REG_BITS | Execute-stage rt field (the load destination) |

## Verification
`stall`, `pc_we` and `ifid_we` are combinational. They are due in the cycle after the edge that places the load in execute and its consumer in decode, which is the second edge after the load sits at address zero. The frozen `pc`, the zero `ex_ctrl` and the held decode fields are due one edge later, and the consumer's control word reaches `ex_ctrl` on the edge after that. Without a stall, the consumer at slot d reaches execute on edge d+2. The bench samples every output at the falling edge after each rising edge, records them per edge, and then compares the edge numbers that these counts predict.

// File: rtl/load_use_stall.sv
module load_use_stall #(
  parameter int REG_BITS  = 5,
  parameter int CTRL_BITS = 8,
  parameter int PC_BITS   = 32,
  parameter int PC_STEP   = 4,
  parameter int MEMRD_BIT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_BITS-1:0]  f_rs,
  input  logic [REG_BITS-1:0]  f_rt,
  input  logic [CTRL_BITS-1:0] f_ctrl,
  output logic [PC_BITS-1:0]   pc,
  output logic                 pc_we,
  output logic                 ifid_we,
  output logic                 stall,
  output logic [REG_BITS-1:0]  id_rs,
  output logic [REG_BITS-1:0]  id_rt,
  output logic [CTRL_BITS-1:0] id_ctrl,
  output logic [CTRL_BITS-1:0] ex_ctrl,
  output logic [REG_BITS-1:0]  ex_rt
);
  localparam logic [PC_BITS-1:0] STEP = PC_BITS'(PC_STEP);

  logic ex_loads, rt_live, src_match;

  assign ex_loads  = ex_ctrl[MEMRD_BIT];
  assign rt_live   = |ex_rt;
  assign src_match = (ex_rt == id_rs) || (ex_rt == id_rt);
  assign stall     = ex_loads && rt_live && src_match;
  assign pc_we     = !stall;
  assign ifid_we   = !stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else if (pc_we) pc <= pc + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_rs   <= '0;
      id_rt   <= '0;
      id_ctrl <= '0;
    end else if (ifid_we) begin
      id_rs   <= f_rs;
      id_rt   <= f_rt;
      id_ctrl <= f_ctrl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_ctrl <= '0;
      ex_rt   <= '0;
    end else begin
      ex_ctrl <= stall ? '0 : id_ctrl;
      ex_rt   <= id_rt;
    end
  end
endmodule

// File: rtl/load_use_stall_chk.sv
module load_use_stall_chk #(
  parameter int REG_BITS  = 5,
  parameter int CTRL_BITS = 8,
  parameter int PC_BITS   = 32,
  parameter int PC_STEP   = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 stall,
  input logic [PC_BITS-1:0]   pc,
  input logic [REG_BITS-1:0]  id_rs,
  input logic [REG_BITS-1:0]  id_rt,
  input logic [CTRL_BITS-1:0] id_ctrl,
  input logic [CTRL_BITS-1:0] ex_ctrl
);
  localparam logic [PC_BITS-1:0] STEP = PC_BITS'(PC_STEP);

  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pc)); // R4
  AST_IFID_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(id_rs) && $stable(id_rt) && $stable(id_ctrl))); // R4
  AST_BUBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (ex_ctrl == '0)); // R5
  AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall); // R6
  AST_HELD_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stall) && !stall |=> (ex_ctrl == $past(id_ctrl))); // R6
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (pc == $past(pc) + STEP)); // R7
  AST_CTRL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (ex_ctrl == $past(id_ctrl))); // R7
endmodule

bind load_use_stall load_use_stall_chk #(
  .REG_BITS(REG_BITS), .CTRL_BITS(CTRL_BITS), .PC_BITS(PC_BITS), .PC_STEP(PC_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .pc(pc),
  .id_rs(id_rs), .id_rt(id_rt), .id_ctrl(id_ctrl), .ex_ctrl(ex_ctrl)
);

// File: tb/load_use_stall_test.sv
module load_use_stall_test;
  localparam int RB = 2;
  localparam int CB = 8;
  localparam int PB = 32;
  localparam int ST = 4;
  localparam int NCYC = 7;
  localparam logic [CB-1:0] CONS = 8'hFB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RB-1:0] f_rs = '0, f_rt = '0;
  logic [CB-1:0] f_ctrl = '0;
  logic [PB-1:0] pc;
  logic pc_we, ifid_we, stall;
  logic [RB-1:0] id_rs, id_rt, ex_rt;
  logic [CB-1:0] id_ctrl, ex_ctrl;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [RB-1:0] p_rs [8];
  logic [RB-1:0] p_rt [8];
  logic [CB-1:0] p_ct [8];

  logic [PB-1:0] s_pc  [NCYC+1];
  logic          s_st  [NCYC+1];
  logic          s_we  [NCYC+1];
  logic [CB-1:0] s_ex  [NCYC+1];
  logic [RB-1:0] s_rs  [NCYC+1];
  logic [RB-1:0] s_rt  [NCYC+1];

  always #4 clk = ~clk;

  load_use_stall #(.REG_BITS(RB), .CTRL_BITS(CB), .PC_BITS(PB), .PC_STEP(ST)) uut (
    .clk(clk), .rst_n(rst_n), .f_rs(f_rs), .f_rt(f_rt), .f_ctrl(f_ctrl),
    .pc(pc), .pc_we(pc_we), .ifid_we(ifid_we), .stall(stall),
    .id_rs(id_rs), .id_rt(id_rt), .id_ctrl(id_ctrl), .ex_ctrl(ex_ctrl), .ex_rt(ex_rt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fetch();
    int idx;
    idx = int'(pc) / ST;
    if (idx < 8) begin
      f_rs = p_rs[idx]; f_rt = p_rt[idx]; f_ctrl = p_ct[idx];
    end else begin
      f_rs = '0; f_rt = '0; f_ctrl = '0;
    end
  endtask

  task automatic run_case(input int mr, input int ld, input int a, input int b, input int d);
    int stl, nst, tag_ok, ex_at;
    string rq;
    for (int i = 0; i < 8; i++) begin
      p_rs[i] = '0; p_rt[i] = '0; p_ct[i] = '0;
    end
    p_rs[0] = RB'(1); p_rt[0] = RB'(ld); p_ct[0] = (mr != 0) ? 8'h05 : 8'h01;
    p_rs[d] = RB'(a); p_rt[d] = RB'(b); p_ct[d] = CONS;

    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(pc == '0 && ex_ctrl == '0 && ex_rt == '0 && id_rs == '0 && id_rt == '0 && id_ctrl == '0,
        "R8 reset state", int'(pc) + int'(ex_ctrl) + int'(id_ctrl), 0);
    fetch();
    rst_n = 1'b1;
    for (int c = 1; c <= NCYC; c++) begin
      @(posedge clk);
      @(negedge clk);
      s_pc[c] = pc; s_st[c] = stall; s_we[c] = pc_we & ifid_we;
      s_ex[c] = ex_ctrl; s_rs[c] = id_rs; s_rt[c] = id_rt;
      if (stall) begin
        if (pc_we || ifid_we) chk(0, "R3 enables low during stall", int'(pc_we) + int'(ifid_we), 0);
      end else begin
        if (!(pc_we && ifid_we)) chk(0, "R3 enables high without stall", int'(pc_we) + int'(ifid_we), 2);
      end
      fetch();
    end

    stl = (mr != 0 && ld != 0 && d == 1 && (a == ld || b == ld)) ? 1 : 0;
    nst = 0;
    for (int c = 1; c <= NCYC; c++) nst += int'(s_st[c]);
    if (stl == 1) rq = "R1 hazard raises stall";
    else if (mr != 0 && ld == 0 && d == 1 && (a == 0 || b == 0)) rq = "R2 register 0 load";
    else rq = "R9 no stall expected";
    chk(nst == stl, rq, nst, stl);

    tag_ok = 1;
    for (int c = 1; c <= NCYC; c++) if (s_we[c] == s_st[c]) tag_ok = 0;
    chk(tag_ok == 1, "R3 enables track stall", tag_ok, 1);

    if (stl == 1) begin
      chk(s_st[2] == 1'b1, "R1 stall in cycle after edge 2", int'(s_st[2]), 1);
      chk(s_pc[3] == s_pc[2], "R4 pc held", int'(s_pc[3]), int'(s_pc[2]));
      chk(s_rs[3] == RB'(a) && s_rt[3] == RB'(b), "R4 IF/ID held", int'(s_rs[3]) * 4 + int'(s_rt[3]), a * 4 + b);
      chk(s_ex[3] == '0, "R5 bubble control zero", int'(s_ex[3]), 0);
      chk(s_ex[4] == CONS, "R6 consumer after one stall", int'(s_ex[4]), int'(CONS));
    end else begin
      ex_at = d + 2;
      chk(s_ex[ex_at] == CONS, "R7 control passes unchanged", int'(s_ex[ex_at]), int'(CONS));
    end
    chk(int'(s_pc[NCYC]) == (NCYC - stl) * ST, "R7 pc advance", int'(s_pc[NCYC]), (NCYC - stl) * ST);
  endtask

  initial begin
    for (int mr = 0; mr < 2; mr++)
      for (int ld = 0; ld < 4; ld++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 4; b++)
            for (int d = 1; d <= 3; d++)
              run_case(mr, ld, a, b, d);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule